// File: doc/BRIEF.md
# Domain-Tagged Hardware Semaphore Gate Bank

This block holds a bank of semaphore gates. Several bus masters share these gates to get mutual exclusion over shared resources. Each gate sits at its own write and read address. Every write carries two sideband fields: the requester's master number and its domain number.

A master claims a free gate by writing its owner code, which is its master number plus one. The gate then holds that owner code and the domain, which the hardware captures from the sideband. The master reads the gate back and compares both fields with its own values to learn whether the claim succeeded. The owner releases the gate by writing zero. Writes from any other master leave a held gate untouched.

A keyed reset register returns gates to the unlocked state. Software writes a first key and then a second key together with a gate number. The named gate is cleared, or every gate is cleared when the number is out of range. The same address reads back whether a reset sequence is waiting for its second key.

Top module: `semgate_bank`

## Requirements
- R1: After reset every gate reads 0 and the reset status at address NUM_GATES reads 0 (idle).
- R2: A write to free gate g (address g, 0..NUM_GATES-1) whose data bits [3:0] equal wr_master+1, with that value nonzero, locks the gate. The gate then reads owner code wr_master+1 in bits [3:0] and wr_domain in bits [5:4]. All other read data bits are 0.
- R3: A write to a gate held by a different master leaves the gate value unchanged, whatever the data.
- R4: The owning master (wr_master+1 equal to the stored owner code) unlocks the gate by writing 0 in bits [3:0], and the gate then reads 0. A write of 0 from any other master is ignored.
- R5: A write to a free gate whose bits [3:0] differ from wr_master+1 is ignored. A nonzero write by the owner is also ignored, so the gate keeps its value.
- R6: A write to address NUM_GATES with 0xE2 in bits [7:0] arms the reset sequencer. The next write to that address with 0x1D in bits [7:0] and gate number n (less than NUM_GATES) in bits [15:8] clears only gate n. The clear takes effect on that write's clock edge.
- R7: If the gate number in the second key write is NUM_GATES or larger, every gate is cleared.
- R8: Bits [1:0] of a read of address NUM_GATES are 1 while the sequencer is armed. They are 0 otherwise, including after the second write.
- R9: If the write to the reset address that follows an accepted 0xE2 does not carry 0x1D, the sequence aborts to idle and no gate changes. A 0x1D write while idle clears nothing.
- R10: Reads of addresses above NUM_GATES return 0. Writes to them change no gate and no reset state.
- R11: Read data appears on rd_data one clock edge after rd_en is sampled high, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address: gates 0..15, reset register at 16 |
| wr_data | input | 16 | Write data: owner code [3:0], or reset key [7:0] with gate number [15:8] |
| wr_master | input | 4 | Requester master number for the write |
| wr_domain | input | 2 | Requester domain number for the write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Registered read data |

## Verification
A gate write and a reset key write take effect on the same rising edge that samples them. A read issued in the cycle after a write therefore already shows the result, and that read's data becomes valid on the edge that samples rd_en. The driver raises rd_en at a falling edge and pushes the expected value into a queue. The monitor counts the rising edge that samples the strobe and compares at the next falling edge, so each comparison falls half a cycle after its data settles and well away from the edge that loads it.

// File: rtl/semgate_pkg.sv
package semgate_pkg;
  localparam int OWN_W  = 4;
  localparam int DOM_W  = 2;
  localparam int VAL_W  = OWN_W + DOM_W;
  localparam int DATA_W = 16;
  localparam int KEY_W  = 8;
  localparam int TGT_W  = 8;
  localparam int STAT_W = 2;

  localparam logic [KEY_W-1:0] KEY_ARM  = 8'hE2;
  localparam logic [KEY_W-1:0] KEY_FIRE = 8'h1D;

  typedef enum logic [STAT_W-1:0] {
    RS_IDLE  = 2'd0,
    RS_ARMED = 2'd1
  } rst_state_e;
endpackage

// File: rtl/semgate_cell.sv
module semgate_cell
  import semgate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [OWN_W-1:0] wr_code,
  input  logic [OWN_W-1:0] req_code,
  input  logic [DOM_W-1:0] req_dom,
  input  logic             clr,
  output logic [VAL_W-1:0] val
);
  logic [VAL_W-1:0] val_q, val_d;
  logic             val_en;
  logic [OWN_W-1:0] owner;

  assign owner = val_q[OWN_W-1:0];

  always_comb begin
    val_d  = val_q;
    val_en = 1'b0;
    if (clr) begin
      val_d  = '0;
      val_en = 1'b1;
    end else if (sel) begin
      if (owner == '0) begin
        if (req_code != '0 && wr_code == req_code) begin
          val_d  = {req_dom, wr_code};
          val_en = 1'b1;
        end
      end else if (owner == req_code && wr_code == '0) begin
        val_d  = '0;
        val_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign val = val_q;

  p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !clr && owner == '0 && req_code != '0 && wr_code == req_code)
      |=> (val_q == {$past(req_dom), $past(wr_code)}));

  p_hold_foreign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !clr && owner != '0 && owner != req_code) |=> $stable(val_q));

  p_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !clr && owner != '0 && owner == req_code && wr_code == '0)
      |=> (val_q == '0));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (val_q == '0));
endmodule

// File: rtl/semgate_rstseq.sv
module semgate_rstseq
  import semgate_pkg::*;
#(
  parameter int NUM_GATES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [KEY_W-1:0]     key,
  input  logic [TGT_W-1:0]     tgt,
  output logic [NUM_GATES-1:0] clr_vec,
  output logic [STAT_W-1:0]    status
);
  rst_state_e state_q, state_d;
  logic       fire;
  logic       hit_all;

  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    if (we) begin
      unique case (state_q)
        RS_IDLE:  if (key == KEY_ARM) state_d = RS_ARMED;
        RS_ARMED: begin
          state_d = RS_IDLE;
          fire    = (key == KEY_FIRE);
        end
        default:  state_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= RS_IDLE;
    else if (we) state_q <= state_d;
  end

  assign hit_all = (tgt >= TGT_W'(NUM_GATES));

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_clr
    assign clr_vec[g] = fire && (hit_all || tgt == TGT_W'(g));
  end

  assign status = state_q;

  p_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && state_q == RS_IDLE && key == KEY_ARM) |=> (status == RS_ARMED));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && state_q == RS_ARMED && key != KEY_FIRE) |-> (clr_vec == '0));

  p_idle_noclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_IDLE) |-> (clr_vec == '0));

  p_clear_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |-> ($onehot(clr_vec) || (&clr_vec)));

  p_back_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> (status == RS_IDLE));
endmodule

// File: rtl/semgate_rdport.sv
module semgate_rdport
  import semgate_pkg::*;
#(
  parameter int NUM_GATES = 16,
  parameter int ADDR_W    = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic [NUM_GATES-1:0][VAL_W-1:0] gate_vals,
  input  logic [STAT_W-1:0]               status,
  output logic [DATA_W-1:0]               rd_data
);
  localparam int GIDX_W = $clog2(NUM_GATES);

  logic [DATA_W-1:0] data_d, data_q;

  always_comb begin
    data_d = '0;
    if (rd_addr < ADDR_W'(NUM_GATES))
      data_d = DATA_W'(gate_vals[rd_addr[GIDX_W-1:0]]);
    else if (rd_addr == ADDR_W'(NUM_GATES))
      data_d = DATA_W'(status);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (rd_en) data_q <= data_d;
  end

  assign rd_data = data_q;

  p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr > ADDR_W'(NUM_GATES)) |=> (rd_data == '0));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/semgate_bank.sv
module semgate_bank
  import semgate_pkg::*;
#(
  parameter int NUM_GATES = 16,
  parameter int ADDR_W    = $clog2(NUM_GATES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [3:0]        wr_master,
  input  logic [1:0]        wr_domain,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data
);
  localparam logic [ADDR_W-1:0] RST_ADDR = ADDR_W'(NUM_GATES);

  logic [NUM_GATES-1:0]            gate_sel;
  logic [NUM_GATES-1:0]            clr_vec;
  logic [NUM_GATES-1:0][VAL_W-1:0] gate_vals;
  logic [OWN_W-1:0]                req_code;
  logic [STAT_W-1:0]               status;
  logic                            rst_we;

  assign req_code = wr_master + OWN_W'(1);
  assign rst_we   = wr_en && (wr_addr == RST_ADDR);

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    assign gate_sel[g] = wr_en && (wr_addr == ADDR_W'(g));

    semgate_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (gate_sel[g]),
      .wr_code  (wr_data[OWN_W-1:0]),
      .req_code (req_code),
      .req_dom  (wr_domain),
      .clr      (clr_vec[g]),
      .val      (gate_vals[g])
    );
  end

  semgate_rstseq #(.NUM_GATES(NUM_GATES)) u_rstseq (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rst_we),
    .key     (wr_data[KEY_W-1:0]),
    .tgt     (wr_data[KEY_W +: TGT_W]),
    .clr_vec (clr_vec),
    .status  (status)
  );

  semgate_rdport #(.NUM_GATES(NUM_GATES), .ADDR_W(ADDR_W)) u_rdport (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .gate_vals (gate_vals),
    .status    (status),
    .rd_data   (rd_data)
  );

  p_spare_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > RST_ADDR) |=> ($stable(gate_vals) && $stable(status)));
endmodule

// File: tb/semgate_bank_test.sv
`timescale 1ns/1ps
module semgate_bank_test;
  localparam int NG = 16;
  localparam int AW = 5;
  localparam logic [AW-1:0] RA = 5'd16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [3:0]    wr_master = '0;
  logic [1:0]    wr_domain = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic issued = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  semgate_bank #(.NUM_GATES(NG)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_master(wr_master), .wr_domain(wr_domain),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [15:0] gv(input logic [1:0] d, input logic [3:0] c);
    return {10'd0, d, c};
  endfunction

  always @(posedge clk) begin
    issued <= rd_en;
    cycles <= cycles + 1;
  end

  always @(negedge clk) begin
    if (issued) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, rd_data, e);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                    input logic [3:0] m, input logic [1:0] dom);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_master = m; wr_domain = dom;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'd0, 16'h0, "R1 gate0");
    rd(5'd5, 16'h0, "R1 gate5");
    rd(5'd15, 16'h0, "R1 gate15");
    rd(RA, 16'h0, "R1 status");

    // R2 lock by master 2 domain 1
    wr(5'd3, 16'h0003, 4'd2, 2'd1);
    rd(5'd3, gv(2'd1, 4'd3), "R2 lock gate3");
    // R11 data holds while rd_en low
    @(negedge clk);
    checks++;
    if (rd_data !== gv(2'd1, 4'd3)) begin
      errors++;
      $display("FAIL R11 hold: got %h expected %h", rd_data, gv(2'd1, 4'd3));
    end

    // R3 foreign claim ignored
    wr(5'd3, 16'h0006, 4'd5, 2'd2);
    rd(5'd3, gv(2'd1, 4'd3), "R3 foreign claim");
    // R4 foreign zero ignored
    wr(5'd3, 16'h0000, 4'd5, 2'd2);
    rd(5'd3, gv(2'd1, 4'd3), "R4 foreign zero");
    // R5 wrong code on free gate, owner nonzero rewrite
    wr(5'd7, 16'h0007, 4'd4, 2'd0);
    rd(5'd7, 16'h0, "R5 wrong code");
    wr(5'd3, 16'h0005, 4'd2, 2'd1);
    rd(5'd3, gv(2'd1, 4'd3), "R5 owner rewrite");
    // R4 owner unlock, then R2 relock by another master
    wr(5'd3, 16'h0000, 4'd2, 2'd1);
    rd(5'd3, 16'h0, "R4 owner unlock");
    wr(5'd3, 16'h0006, 4'd5, 2'd2);
    rd(5'd3, gv(2'd2, 4'd6), "R2 relock gate3");
    wr(5'd0, 16'h0001, 4'd0, 2'd3);
    wr(5'd15, 16'h000F, 4'd14, 2'd2);
    rd(5'd0, gv(2'd3, 4'd1), "R2 lock gate0");
    rd(5'd15, gv(2'd2, 4'd15), "R2 lock gate15");

    // R6 R8 single gate reset
    wr(RA, 16'h00E2, 4'd1, 2'd0);
    rd(RA, 16'h1, "R8 armed");
    wr(RA, 16'h031D, 4'd1, 2'd0);
    rd(5'd3, 16'h0, "R6 gate3 cleared");
    rd(5'd0, gv(2'd3, 4'd1), "R6 gate0 kept");
    rd(5'd15, gv(2'd2, 4'd15), "R6 gate15 kept");
    rd(RA, 16'h0, "R8 idle after fire");

    // R9 abort and stray fire
    wr(RA, 16'h00E2, 4'd1, 2'd0);
    wr(RA, 16'h0055, 4'd1, 2'd0);
    rd(RA, 16'h0, "R9 abort idle");
    rd(5'd0, gv(2'd3, 4'd1), "R9 abort no change");
    wr(RA, 16'h001D, 4'd1, 2'd0);
    rd(5'd0, gv(2'd3, 4'd1), "R9 idle fire ignored");

    // R10 spare addresses
    wr(5'd20, 16'h00E2, 4'd0, 2'd0);
    rd(RA, 16'h0, "R10 spare write no arm");
    wr(5'd17, 16'h0001, 4'd0, 2'd0);
    rd(5'd17, 16'h0, "R10 spare read");
    rd(5'd31, 16'h0, "R10 spare read top");
    rd(5'd0, gv(2'd3, 4'd1), "R10 gate0 intact");

    // R7 all-gate reset with boundary number 16
    wr(RA, 16'h00E2, 4'd1, 2'd0);
    wr(RA, 16'h101D, 4'd1, 2'd0);
    rd(5'd0, 16'h0, "R7 gate0 all");
    rd(5'd15, 16'h0, "R7 gate15 all");
    // R6 boundary number 15 clears only gate 15
    wr(5'd14, 16'h0003, 4'd2, 2'd0);
    wr(5'd15, 16'h0004, 4'd3, 2'd1);
    wr(RA, 16'h00E2, 4'd1, 2'd0);
    wr(RA, 16'h0F1D, 4'd1, 2'd0);
    rd(5'd15, 16'h0, "R6 gate15 named");
    rd(5'd14, gv(2'd0, 4'd3), "R6 gate14 kept");
    // R7 number 0xFF
    wr(RA, 16'h00E2, 4'd1, 2'd0);
    wr(RA, 16'hFF1D, 4'd1, 2'd0);
    rd(5'd14, 16'h0, "R7 gate14 all ff");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 drain: got %0d expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule